// File: doc/BRIEF.md
# Addressed Serial Frame Receiver

This block takes a three-wire serial stream (bit clock, data, active-low frame sync), samples it in a faster system clock domain, and turns each complete 24-bit frame into a single write toward a bank of four input registers. Each frame carries a 5-bit device address, a 2-bit register select and a 14-bit code. The frame is acted on only when frame sync returns high, never while bits are still arriving.

Several receivers can share one serial bus. Each one has its own address set by strap inputs, and it drops frames meant for another device. A bypass input turns off the address comparison, so that one frame can write the same register in every device on the bus. The level of the load input at the end of the frame is sent out with the write, so the downstream latch logic can tell an immediate update from a deferred one. A frame whose bit count is not exactly 24 produces no write and raises an error pulse.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, wr_valid and frame_err are 0, and wr_chan, wr_data and wr_load are 0.
- R2: Bits are taken on rising bit-clock edges while frame sync is low, MSB first. The first bit received is frame bit 23. wr_data carries frame bits 13..0 and wr_chan carries bits 17..16.
- R3: No write and no error is produced while frame sync stays low, even after 24 bits. The result appears within 4 system clocks of frame sync rising.
- R4: With addr_bypass low, a 24-bit frame is written only if frame bits 23..19 equal strap_addr. A mismatching frame produces neither wr_valid nor frame_err and leaves wr_chan and wr_data unchanged.
- R5: With addr_bypass high, frame bits 23..19 are ignored and every 24-bit frame is written to the channel in bits 17..16.
- R6: A frame that ends with a bit count other than 24 (including zero) produces no write and a frame_err pulse exactly one cycle wide.
- R7: Each accepted frame produces exactly one wr_valid pulse, one cycle wide.
- R8: wr_load, valid with wr_valid, equals the load input level at the end of the frame.
- R9: Frame bits 18, 15 and 14 have no effect on acceptance or on wr_chan and wr_data.
- R10: Bit-clock edges while frame sync is high are ignored. Each falling edge of frame sync starts a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial bit clock, asynchronous |
| sdin_in | input | 1 | Serial data, asynchronous |
| fsync_n_in | input | 1 | Active-low frame sync, asynchronous |
| load_n_in | input | 1 | Load input level, asynchronous |
| strap_addr | input | 5 | Hardwired device address |
| addr_bypass | input | 1 | High: ignore the address field |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_chan | output | 2 | Register select of the write |
| wr_data | output | 14 | Code of the write |
| wr_load | output | 1 | Load input level captured at frame end |
| frame_err | output | 1 | One-cycle pulse on a frame of the wrong length |

## Verification
The assertions assume four things. strap_addr and addr_bypass are held steady across a frame. Each bit-clock phase lasts several system clocks, so every edge gets through the synchronizer. Data is stable around each rising bit-clock edge. Frame sync never changes in the same cycle as a bit-clock edge. The bench drives each bit-clock phase for four system clocks. It changes data only while the bit clock is low and keeps a four-clock gap around each frame-sync edge. It changes straps and bypass only between frames. Random frames, lengths and addresses are mixed with directed cases, and all of them follow these rules.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int FRAME_BITS  = 24,
  parameter int ADDR_W      = 5,
  parameter int CHAN_W      = 2,
  parameter int CODE_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdin_in,
  input  logic              fsync_n_in,
  input  logic              load_n_in,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              addr_bypass,
  output logic              wr_valid,
  output logic [CHAN_W-1:0] wr_chan,
  output logic [CODE_W-1:0] wr_data,
  output logic              wr_load,
  output logic              frame_err
);
  localparam int ADDR_LSB = FRAME_BITS - ADDR_W;
  localparam int CHAN_LSB = ADDR_LSB - 1 - CHAN_W;
  localparam int CNT_W    = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] sclk_q, din_q, fs_q, ld_q;
  logic sclk_d, fs_d;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic in_frame;

  wire sclk_s = sclk_q[SYNC_STAGES-1];
  wire din_s  = din_q[SYNC_STAGES-1];
  wire fs_s   = fs_q[SYNC_STAGES-1];
  wire ld_s   = ld_q[SYNC_STAGES-1];

  wire sclk_rise = sclk_s & ~sclk_d;
  wire fs_fall   = ~fs_s & fs_d;
  wire fs_rise   = fs_s & ~fs_d;

  wire [ADDR_W-1:0] f_addr = shreg[FRAME_BITS-1 -: ADDR_W];
  wire [CHAN_W-1:0] f_chan = shreg[CHAN_LSB +: CHAN_W];
  wire [CODE_W-1:0] f_code = shreg[CODE_W-1:0];
  wire len_ok  = (cnt == CNT_FULL);
  wire addr_ok = addr_bypass | (f_addr == strap_addr);
  wire commit  = fs_rise & in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      din_q  <= '0;
      fs_q   <= '1;
      ld_q   <= '1;
      sclk_d <= 1'b0;
      fs_d   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk_in};
      din_q  <= {din_q[SYNC_STAGES-2:0], sdin_in};
      fs_q   <= {fs_q[SYNC_STAGES-2:0], fsync_n_in};
      ld_q   <= {ld_q[SYNC_STAGES-2:0], load_n_in};
      sclk_d <= sclk_s;
      fs_d   <= fs_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      in_frame <= 1'b0;
    end else if (fs_fall) begin
      shreg    <= '0;
      cnt      <= '0;
      in_frame <= 1'b1;
    end else if (fs_rise) begin
      in_frame <= 1'b0;
    end else if (in_frame && !fs_s && sclk_rise) begin
      shreg <= {shreg[FRAME_BITS-2:0], din_s};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      wr_chan   <= '0;
      wr_data   <= '0;
      wr_load   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      wr_valid  <= commit & len_ok & addr_ok;
      frame_err <= commit & ~len_ok;
      if (commit && len_ok && addr_ok) begin
        wr_chan <= f_chan;
        wr_data <= f_code;
        wr_load <= ld_s;
      end
    end
  end

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !wr_valid);
  p_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || frame_err) |-> $past(fs_s));
  p_addr_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !$past(addr_bypass)) |-> ($past(f_addr) == $past(strap_addr)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> ($stable(wr_data) && $stable(wr_chan)));
  p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(cnt) == CNT_FULL));
endmodule

// File: tb/tb_serial_frame_rx.sv
module tb_serial_frame_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_in = 1'b0, sdin_in = 1'b0, fsync_n_in = 1'b1, load_n_in = 1'b1;
  logic [4:0] strap_addr = 5'h13;
  logic addr_bypass = 1'b0;
  logic wr_valid, wr_load, frame_err;
  logic [1:0] wr_chan;
  logic [13:0] wr_data;

  int checks = 0, fails = 0;
  int n_valid = 0, n_err = 0, n_wide = 0;
  logic prev_v = 1'b0, prev_e = 1'b0;
  logic [1:0] cap_chan;
  logic [13:0] cap_data;
  logic cap_load;
  bit done = 0;

  always #5 clk = ~clk;

  serial_frame_rx dut (.*);

  always @(negedge clk) begin
    if (wr_valid) begin
      n_valid++; cap_chan = wr_chan; cap_data = wr_data; cap_load = wr_load;
    end
    if (frame_err) n_err++;
    if ((wr_valid && prev_v) || (frame_err && prev_e)) n_wide++;
    prev_v = wr_valid; prev_e = frame_err;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit accepts(logic [23:0] w, int nb, logic [4:0] st, logic byp);
    return (nb == 24) && (byp || w[23:19] == st);
  endfunction

  task automatic send(logic [23:0] w, int nb, logic ld);
    int v0, e0;
    load_n_in = ld;
    fsync_n_in = 1'b0;
    tick(4);
    for (int i = 0; i < nb; i++) begin
      sdin_in = (i < 24) ? w[23-i] : 1'b1;
      tick(4);
      sclk_in = 1'b1;
      tick(4);
      sclk_in = 1'b0;
    end
    v0 = n_valid; e0 = n_err;
    tick(8);
    chk(n_valid == v0 && n_err == e0, "R3 no result before frame end", n_valid + n_err, v0 + e0);
    fsync_n_in = 1'b1;
    tick(4);
  endtask

  task automatic frame_check(logic [23:0] w, int nb, logic ld, string tag);
    int v0, e0;
    bit acc;
    logic [1:0] oc;
    logic [13:0] od;
    v0 = n_valid; e0 = n_err; oc = cap_chan; od = cap_data;
    acc = accepts(w, nb, strap_addr, addr_bypass);
    send(w, nb, ld);
    tick(4);
    chk(n_valid == v0 + (acc ? 1 : 0), tag, n_valid - v0, acc ? 1 : 0);
    chk(n_err == e0 + ((nb != 24) ? 1 : 0), {tag, " R6 err"}, n_err - e0, (nb != 24) ? 1 : 0);
    if (acc) begin
      chk(cap_data == w[13:0], {tag, " R2 data"}, cap_data, w[13:0]);
      chk(cap_chan == w[17:16], {tag, " R2 chan"}, cap_chan, w[17:16]);
      chk(cap_load == ld, {tag, " R8 load"}, cap_load, ld);
    end else begin
      chk(cap_data == od && cap_chan == oc, {tag, " R4 held"}, cap_data, od);
    end
  endtask

  initial begin
    tick(3);
    chk(wr_valid == 0 && frame_err == 0, "R1 strobes", {wr_valid, frame_err}, 0);
    chk(wr_chan == 0 && wr_data == 0 && wr_load == 0, "R1 data", wr_data, 0);
    rst_n = 1'b1;
    tick(4);
    frame_check({5'h13, 1'b0, 2'd2, 2'b00, 14'h2A5C}, 24, 1'b0, "R2 match");
    frame_check({5'h13, 1'b0, 2'd1, 2'b00, 14'h3FFF}, 24, 1'b1, "R8 load high");
    frame_check({5'h12, 1'b0, 2'd3, 2'b00, 14'h0001}, 24, 1'b0, "R4 mismatch");
    addr_bypass = 1'b1;
    frame_check({5'h05, 1'b0, 2'd3, 2'b00, 14'h1234}, 24, 1'b0, "R5 bypass");
    addr_bypass = 1'b0;
    frame_check({5'h13, 1'b1, 2'd0, 2'b11, 14'h0ABC}, 24, 1'b1, "R9 ignored bits");
    frame_check({5'h13, 1'b0, 2'd1, 2'b00, 14'h1111}, 23, 1'b0, "R6 short");
    frame_check({5'h13, 1'b0, 2'd1, 2'b00, 14'h2222}, 25, 1'b0, "R6 long");
    frame_check(24'h0, 0, 1'b0, "R6 empty");
    for (int i = 0; i < 6; i++) begin
      sdin_in = i[0]; tick(4); sclk_in = 1'b1; tick(4); sclk_in = 1'b0;
    end
    tick(4);
    frame_check({5'h13, 1'b0, 2'd3, 2'b00, 14'h0F0F}, 24, 1'b1, "R10 idle clocks");
    strap_addr = 5'h00;
    frame_check({5'h00, 1'b0, 2'd0, 2'b00, 14'h0000}, 24, 1'b0, "R4 zero addr");
    for (int k = 0; k < 40; k++) begin
      logic [23:0] w;
      int nb;
      w = $urandom;
      if ($urandom_range(1, 0) == 1) w[23:19] = strap_addr;
      nb = ($urandom_range(7, 0) == 0) ? $urandom_range(26, 20) : 24;
      addr_bypass = ($urandom_range(3, 0) == 0);
      if (k == 20) strap_addr = 5'h1F;
      frame_check(w, nb, $urandom_range(1, 0), "R2 random");
      addr_bypass = 1'b0;
    end
    chk(n_wide == 0, "R7 pulse width", n_wide, 0);
    done = 1;
  end

  initial begin
    void'($urandom(32'h5EED));
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); fails++; checks++; $display("FAIL watchdog actual=1 expected=0"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule